// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the four left/right partial-word instructions of a 32-bit little-endian load/store pipeline: load-left, load-right, store-left and store-right. On a start pulse it takes a base register, a 16-bit signed displacement, the target register's index and value, and the index and value of the load that is still waiting in the delay slot. It forms the effective address, reads the word-aligned location, and merges bytes according to the low two address bits.

A load produces a merged register value, which is presented as a new delayed-load write with its register index. A store produces a merged word, which is written back to the same aligned address in the cycle after the read. Memory reads are combinational: the data on `mem_rdata` must be valid in the same cycle that `mem_rd` is high.

Top module: `unaligned_merge`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `mem_wr`, `ld_valid` and `done` are all low.
- R2: The effective address is `base + sign_extend(disp)`. The memory address is that sum with bits 1:0 cleared, for both the read and the write-back. The byte offset used for merging is bits 1:0 of the sum.
- R3: Load-left (`op`=2'b00), with offset k: k=3 gives mem. k=2 gives (prior & 0x000000FF) | (mem << 8). k=1 gives (prior & 0x0000FFFF) | (mem << 16). k=0 gives (prior & 0x00FFFFFF) | (mem << 24).
- R4: Load-right (`op`=2'b01), with offset k: k=0 gives mem. k=3 gives (prior & 0xFFFFFF00) | (mem >> 24). k=2 gives (prior & 0xFFFF0000) | (mem >> 16). k=1 gives (prior & 0xFF000000) | (mem >> 8).
- R5: Store-left (`op`=2'b10), with offset k: k=3 gives reg. k=2 gives (mem & 0xFF000000) | (reg >> 8). k=1 gives (mem & 0xFFFF0000) | (reg >> 16). k=0 gives (mem & 0xFFFFFF00) | (reg >> 24).
- R6: Store-right (`op`=2'b11), with offset k: k=0 gives reg. k=3 gives (mem & 0x00FFFFFF) | (reg << 24). k=2 gives (mem & 0x0000FFFF) | (reg << 16). k=1 gives (mem & 0x000000FF) | (reg << 8).
- R7: For loads, "prior" is `pend_val` when `pend_idx` equals `rt_idx`, and `rt_val` otherwise. Stores always merge `rt_val`, whatever the pending load.
- R8: A start accepted while idle raises `mem_rd` in the next cycle. A load then pulses `ld_valid` and `done` for one cycle in the following cycle, with `ld_idx` set to `rt_idx`. A store instead raises `mem_wr` and `done` for one cycle in the following cycle, carrying the merged word. After either, the unit is idle again.
- R9: A start that arrives while `busy` is high is ignored. It does not change the address, the merged data or the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| rt_idx | input | 5 | Target register index |
| rt_val | input | 32 | Target register file value |
| pend_idx | input | 5 | Index of the load waiting in the delay slot |
| pend_val | input | 32 | Value of the load waiting in the delay slot |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Read data, valid while `mem_rd` is high |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Merged store word |
| ld_valid | output | 1 | Delayed-load result valid |
| ld_idx | output | 5 | Destination register of the result |
| ld_data | output | 32 | Merged load result |
| done | output | 1 | Operation complete |

## Verification
The hardest case to reach is a load whose target register matches the pending delayed load. Here the prior contents must come from the forwarding value, not the register file. The stimulus gives `pend_val` and `rt_val` contrasting byte patterns and sets the two indices equal. Every offset then shows at once which source filled the preserved bytes.

A second hard case is a start that arrives mid-sequence. The bench pulses `start` with a different address during the read cycle and checks that the write-back still carries the original address and data.

// File: rtl/unaligned_merge.sv
module unaligned_merge #(
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [DW-1:0] base,
  input  logic [IW-1:0] disp,
  input  logic [RW-1:0] rt_idx,
  input  logic [DW-1:0] rt_val,
  input  logic [RW-1:0] pend_idx,
  input  logic [DW-1:0] pend_val,
  output logic          busy,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_valid,
  output logic [RW-1:0] ld_idx,
  output logic [DW-1:0] ld_data,
  output logic          done
);
  localparam logic [1:0] S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2;
  localparam logic [DW-1:0] ONES = '1;

  logic [1:0]    state;
  logic [1:0]    op_q, off_q;
  logic [DW-1:0] addr_q, prior_q, reg_q, wdata_q;
  logic [RW-1:0] idx_q;

  logic [DW-1:0] eff;
  logic [4:0]    sh_up, sh_dn;
  logic [DW-1:0] ld_merge, st_merge;

  assign eff   = base + {{(DW-IW){disp[IW-1]}}, disp};
  assign sh_up = {~off_q, 3'b000};
  assign sh_dn = {off_q, 3'b000};

  assign ld_merge = op_q[0]
    ? ((prior_q & ~(ONES >> sh_dn)) | (mem_rdata >> sh_dn))
    : ((prior_q & ~(ONES << sh_up)) | (mem_rdata << sh_up));
  assign st_merge = op_q[0]
    ? ((mem_rdata & ~(ONES << sh_dn)) | (reg_q << sh_dn))
    : ((mem_rdata & ~(ONES >> sh_up)) | (reg_q >> sh_up));

  assign busy      = state != S_IDLE;
  assign mem_rd    = state == S_RD;
  assign mem_wr    = state == S_WR;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign done      = ld_valid | mem_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      off_q    <= '0;
      addr_q   <= '0;
      prior_q  <= '0;
      reg_q    <= '0;
      wdata_q  <= '0;
      idx_q    <= '0;
      ld_valid <= 1'b0;
      ld_idx   <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q    <= op;
          off_q   <= eff[1:0];
          addr_q  <= {eff[DW-1:2], 2'b00};
          prior_q <= (pend_idx == rt_idx) ? pend_val : rt_val;
          reg_q   <= rt_val;
          idx_q   <= rt_idx;
          state   <= S_RD;
        end
        S_RD: if (!op_q[1]) begin
          ld_valid <= 1'b1;
          ld_idx   <= idx_q;
          ld_data  <= ld_merge;
          state    <= S_IDLE;
        end else begin
          wdata_q <= st_merge;
          state   <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_addr[1:0] == 2'b00);
  a_r8_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  a_r2_wr_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $stable(mem_addr));
  a_r8_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
  a_r8_rd_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_rd);
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(ld_valid && mem_wr));
endmodule

// File: tb/unaligned_merge_test.sv
module unaligned_merge_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] op = 0;
  logic [31:0] base = 0, rt_val = 0, pend_val = 0, mem_rdata = 0;
  logic [15:0] disp = 0;
  logic [4:0] rt_idx = 0, pend_idx = 0;
  logic busy, mem_rd, mem_wr, ld_valid, done;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [4:0] ld_idx;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  unaligned_merge uut (.clk, .rst_n, .start, .op, .base, .disp, .rt_idx, .rt_val,
    .pend_idx, .pend_val, .busy, .mem_addr, .mem_rd, .mem_rdata, .mem_wr,
    .mem_wdata, .ld_valid, .ld_idx, .ld_data, .done);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [1:0] o, logic [1:0] k,
      logic [31:0] m, logic [31:0] p, logic [31:0] r);
    case ({o, k})
      4'b0000: return (p & 32'h00FFFFFF) | (m << 24);
      4'b0001: return (p & 32'h0000FFFF) | (m << 16);
      4'b0010: return (p & 32'h000000FF) | (m << 8);
      4'b0011: return m;
      4'b0100: return m;
      4'b0101: return (p & 32'hFF000000) | (m >> 8);
      4'b0110: return (p & 32'hFFFF0000) | (m >> 16);
      4'b0111: return (p & 32'hFFFFFF00) | (m >> 24);
      4'b1000: return (m & 32'hFFFFFF00) | (r >> 24);
      4'b1001: return (m & 32'hFFFF0000) | (r >> 16);
      4'b1010: return (m & 32'hFF000000) | (r >> 8);
      4'b1011: return r;
      4'b1100: return r;
      4'b1101: return (m & 32'h000000FF) | (r << 8);
      4'b1110: return (m & 32'h0000FFFF) | (r << 16);
      default: return (m & 32'h00FFFFFF) | (r << 24);
    endcase
  endfunction

  // one complete operation; poke=1 pulses start again during the read cycle
  task automatic run(string req, logic [1:0] o, logic [31:0] b, logic [15:0] d,
      logic [4:0] ri, logic [31:0] rv, logic [4:0] pi, logic [31:0] pv,
      logic [31:0] m, bit poke);
    logic [31:0] eff, prior, exp;
    eff = b + {{16{d[15]}}, d};
    prior = (o[1] == 1'b0 && pi == ri) ? pv : rv;
    exp = model(o, eff[1:0], m, prior, rv);
    @(negedge clk);
    op = o; base = b; disp = d; rt_idx = ri; rt_val = rv;
    pend_idx = pi; pend_val = pv; mem_rdata = m; start = 1;
    @(negedge clk);
    start = 0;
    chk({req, " R8 rd"}, {31'd0, mem_rd}, 1);
    chk({req, " R2 addr"}, mem_addr, eff & 32'hFFFFFFFC);
    if (poke) begin
      start = 1; base = b ^ 32'h00F0_0004; rt_val = ~rv; op = ~o;
    end
    @(negedge clk);
    start = 0;
    if (!o[1]) begin
      chk({req, " R8 ldv"}, {31'd0, ld_valid & done}, 1);
      chk({req, " R8 idx"}, {27'd0, ld_idx}, {27'd0, ri});
      chk({req, " data"}, ld_data, exp);
    end else begin
      chk({req, " R8 wr"}, {31'd0, mem_wr & done}, 1);
      chk({req, " R2 waddr"}, mem_addr, eff & 32'hFFFFFFFC);
      chk({req, " data"}, mem_wdata, exp);
      @(negedge clk);
    end
    chk({req, " R8 idle"}, {29'd0, busy, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset", {27'd0, busy, mem_rd, mem_wr, ld_valid, done}, 0);
  endtask

  task automatic t_op(string req, logic [1:0] o);
    for (int k = 0; k < 4; k++)
      run(req, o, 32'h8000_1003, 16'(k - 3), 5'd7, 32'hA1B2C3D4, 5'd9,
          32'h5566_7788, 32'h1122_3344 + 32'(k), 0);
    run({req, " R2 negdisp"}, o, 32'h0000_2001, 16'hFFF2, 5'd3, 32'hCAFEF00D,
        5'd4, 32'h0, 32'hDEAD_BEEF, 0);
  endtask

  task automatic t_forward;
    for (int k = 0; k < 4; k++) begin
      run("R7 fwd lwl", 2'b00, 32'h100, 16'(k), 5'd12, 32'hAAAA_AAAA, 5'd12,
          32'h5555_5555, 32'h0102_0304, 0);
      run("R7 fwd lwr", 2'b01, 32'h100, 16'(k), 5'd12, 32'hAAAA_AAAA, 5'd12,
          32'h5555_5555, 32'h0102_0304, 0);
    end
    run("R7 store no fwd", 2'b11, 32'h101, 16'h0, 5'd12, 32'hAAAA_AAAA, 5'd12,
        32'h5555_5555, 32'h0102_0304, 0);
  endtask

  task automatic t_busy;
    run("R9 busy store", 2'b10, 32'h4000_0002, 16'h0, 5'd1, 32'h8899AABB, 5'd0,
        32'h0, 32'hF0E0D0C0, 1);
    run("R9 busy load", 2'b01, 32'h4000_0001, 16'h0, 5'd2, 32'h8899AABB, 5'd0,
        32'h0, 32'hF0E0D0C0, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk) rst_n = 1;
    t_reset();
    t_op("R3 lwl", 2'b00);
    t_op("R4 lwr", 2'b01);
    t_op("R5 swl", 2'b10);
    t_op("R6 swr", 2'b11);
    t_forward();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule